// File: doc/BRIEF.md
# Receive Alarm Interrupt Status Register

This block is the sticky interrupt status register of a DS3 receive framer. Each clock it takes two kinds of input from the framer. Two are single-cycle error pulses: the C-bit parity error and the P-bit error. Six are present alarm levels: LOS, AIS, Idle, FERF, AIC and OOF. For a level input, the block compares the level with its value on the previous clock. Any change, rising or falling, counts as an event. Every event sets its own flag, and the flag stays set until software reads the register.

A read is a strobe together with the register address 0x13. The accumulated flags appear on the read data port one cycle later, and the same read clears all the flags. An event that arrives in the read cycle is kept for the next read and is not lost. The C-bit parity error flag can only set while the channel is in C-bit parity framing mode.

An interrupt output reports whether any set flag is also enabled in an eight-bit mask. The present AIS and Idle levels are not stored here. They belong to a separate status register.

Top module: `rx_alarm_irq_reg`

## Requirements
- R1: After reset the flags hold 0x40 (only the LOS flag set), rd_data is 0 and irq is 0.
- R2: Flag bit positions are: bit 7 C-bit parity error, bit 6 LOS, bit 5 AIS, bit 4 Idle, bit 3 FERF, bit 2 AIC, bit 1 OOF, bit 0 P-bit error.
- R3: A cycle with rd_en=1 and addr=0x13 places the current flags on rd_data at the next clock edge and clears every flag at that edge.
- R4: A read strobe at any other address puts 0 on rd_data and leaves the flags unchanged.
- R5: A one-cycle pulse on p_err_evt or cp_err_evt sets its flag, and the flag stays set across any number of cycles until a read at 0x13.
- R6: A rising or a falling edge on any of the six level inputs sets that input's flag.
- R7: cp_err_evt has no effect while cbit_mode=0.
- R8: An event in the same cycle as a read at 0x13 is not returned by that read. Its flag is set after the read clears the others.
- R9: irq is 1 exactly when some flag bit is 1 and the matching irq_en bit is 1.
- R10: A level input that stays constant sets no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | 8 | Read address |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 8 | Registered read data |
| cbit_mode | input | 1 | 1 = C-bit parity framing |
| cp_err_evt | input | 1 | C-bit parity error pulse |
| p_err_evt | input | 1 | P-bit error pulse |
| los_lvl | input | 1 | Loss-of-signal level |
| ais_lvl | input | 1 | AIS level |
| idle_lvl | input | 1 | Idle level |
| ferf_lvl | input | 1 | Far-end receive failure level |
| aic_lvl | input | 1 | Application-identification level |
| oof_lvl | input | 1 | Out-of-frame level |
| irq_en | input | 8 | Interrupt enable mask, same bit layout as the flags |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach is an event that collides with the clearing read. To set it up, the level edge or error pulse must be driven in exactly the cycle that carries the read strobe. The read must then return the flags without that event, and the event must still appear at the next read. The bench drives a level change and a read strobe on the same falling edge. It also runs a pseudo-random stretch in which reads, pulses and level toggles overlap freely. Throughout, a behavioural model is compared with the design on every clock.

// File: rtl/rxa_pkg.sv
package rxa_pkg;
    localparam int NFLAGS = 8;
    localparam int B_CPERR = 7;
    localparam int B_LOS   = 6;
    localparam int B_AIS   = 5;
    localparam int B_IDLE  = 4;
    localparam int B_FERF  = 3;
    localparam int B_AIC   = 2;
    localparam int B_OOF   = 1;
    localparam int B_PERR  = 0;
    typedef logic [NFLAGS-1:0] flag_vec_t;
endpackage

// File: rtl/rxa_event_gen.sv
module rxa_event_gen #(
    parameter int N = 8,
    parameter logic [N-1:0] LEVEL_MASK = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] raw,
    input  logic [N-1:0] qual,
    output logic [N-1:0] ev
);
    logic [N-1:0] hit;

    for (genvar i = 0; i < N; i++) begin : g_bit
        if (LEVEL_MASK[i]) begin : g_level
            logic prev_q;
            always_ff @(posedge clk) begin
                if (!rst_n) prev_q <= 1'b0;
                else        prev_q <= raw[i];
            end
            assign hit[i] = raw[i] ^ prev_q;
        end else begin : g_pulse
            assign hit[i] = raw[i];
        end
    end

    assign ev = hit & qual;
endmodule

// File: rtl/rxa_flag_bank.sv
module rxa_flag_bank #(
    parameter int N = 8,
    parameter logic [N-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] ev,
    input  logic         clr,
    output logic [N-1:0] flags
);
    logic [N-1:0] flags_d;

    always_comb begin
        flags_d = clr ? '0 : flags;
        flags_d = flags_d | ev;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) flags <= RST_VAL;
        else        flags <= flags_d;
    end
endmodule

// File: rtl/rxa_read_port.sv
module rxa_read_port #(
    parameter int AW = 8,
    parameter int N  = 8,
    parameter logic [AW-1:0] REG_ADDR = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr,
    input  logic          rd_en,
    input  logic [N-1:0]  flags,
    output logic          hit,
    output logic [N-1:0]  rd_data
);
    assign hit = rd_en && (addr == REG_ADDR);

    always_ff @(posedge clk) begin
        if (!rst_n)   rd_data <= '0;
        else if (hit) rd_data <= flags;
        else          rd_data <= '0;
    end
endmodule

// File: rtl/rx_alarm_irq_reg.sv
module rx_alarm_irq_reg
    import rxa_pkg::*;
#(
    parameter int AW = 8,
    parameter logic [AW-1:0] REG_ADDR = 8'h13,
    parameter logic [NFLAGS-1:0] RST_VAL = 8'h40
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr,
    input  logic          rd_en,
    output logic [7:0]    rd_data,
    input  logic          cbit_mode,
    input  logic          cp_err_evt,
    input  logic          p_err_evt,
    input  logic          los_lvl,
    input  logic          ais_lvl,
    input  logic          idle_lvl,
    input  logic          ferf_lvl,
    input  logic          aic_lvl,
    input  logic          oof_lvl,
    input  logic [7:0]    irq_en,
    output logic          irq
);
    localparam flag_vec_t LEVELS = flag_vec_t'((1 << B_LOS) | (1 << B_AIS) | (1 << B_IDLE)
                                             | (1 << B_FERF) | (1 << B_AIC) | (1 << B_OOF));

    flag_vec_t raw_w, qual_w, ev_w, flags_q;
    logic      rd_hit;

    always_comb begin
        raw_w          = '0;
        raw_w[B_CPERR] = cp_err_evt;
        raw_w[B_LOS]   = los_lvl;
        raw_w[B_AIS]   = ais_lvl;
        raw_w[B_IDLE]  = idle_lvl;
        raw_w[B_FERF]  = ferf_lvl;
        raw_w[B_AIC]   = aic_lvl;
        raw_w[B_OOF]   = oof_lvl;
        raw_w[B_PERR]  = p_err_evt;
        qual_w         = '1;
        qual_w[B_CPERR] = cbit_mode;
    end

    rxa_event_gen #(.N(NFLAGS), .LEVEL_MASK(LEVELS)) u_evt (
        .clk(clk), .rst_n(rst_n), .raw(raw_w), .qual(qual_w), .ev(ev_w)
    );

    rxa_flag_bank #(.N(NFLAGS), .RST_VAL(RST_VAL)) u_flags (
        .clk(clk), .rst_n(rst_n), .ev(ev_w), .clr(rd_hit), .flags(flags_q)
    );

    rxa_read_port #(.AW(AW), .N(NFLAGS), .REG_ADDR(REG_ADDR)) u_rd (
        .clk(clk), .rst_n(rst_n), .addr(addr), .rd_en(rd_en),
        .flags(flags_q), .hit(rd_hit), .rd_data(rd_data)
    );

    assign irq = |(flags_q & irq_en);
endmodule

// File: rtl/rxa_irq_chk.sv
module rxa_irq_chk #(
    parameter int AW = 8,
    parameter logic [AW-1:0] REG_ADDR = 8'h13
) (
    input logic          clk,
    input logic          rst_n,
    input logic [AW-1:0] addr,
    input logic          rd_en,
    input logic [7:0]    rd_data,
    input logic          cbit_mode,
    input logic          irq,
    input logic [7:0]    flags,
    input logic [7:0]    ev
);
    logic hit_c;
    assign hit_c = rd_en && (addr == REG_ADDR);

    // R3
    read_returns_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit_c |=> rd_data == $past(flags));

    // R8
    read_keeps_new_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit_c |=> flags == $past(ev));

    // R5
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !hit_c |=> (flags & $past(flags)) == $past(flags));

    // R4
    other_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr != REG_ADDR) |=> rd_data == 8'h00);

    // R7
    cp_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cbit_mode && !flags[7] && !hit_c) |=> !flags[7]);

    // R9
    irq_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_c && ev == 8'h00) |=> !irq);
endmodule

bind rx_alarm_irq_reg rxa_irq_chk #(.AW(AW), .REG_ADDR(REG_ADDR)) u_chk (
    .clk(clk), .rst_n(rst_n), .addr(addr), .rd_en(rd_en), .rd_data(rd_data),
    .cbit_mode(cbit_mode), .irq(irq), .flags(flags_q), .ev(ev_w)
);

// File: tb/rx_alarm_irq_reg_test.sv
module rx_alarm_irq_reg_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] addr = 8'h00;
    logic       rd_en = 1'b0;
    logic [7:0] rd_data;
    logic       cbit_mode = 1'b0;
    logic       cp_err_evt = 1'b0, p_err_evt = 1'b0;
    logic       los_lvl = 1'b0, ais_lvl = 1'b0, idle_lvl = 1'b0;
    logic       ferf_lvl = 1'b0, aic_lvl = 1'b0, oof_lvl = 1'b0;
    logic [7:0] irq_en = 8'h00;
    logic       irq;

    int errors = 0;
    int checks = 0;
    bit done = 0;
    string cur_req = "R1";

    // behavioural model state
    bit [7:0] m_flags;
    bit [7:0] m_rd;
    bit [7:0] m_prev;

    always #4 clk = ~clk;

    rx_alarm_irq_reg uut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .rd_en(rd_en), .rd_data(rd_data),
        .cbit_mode(cbit_mode), .cp_err_evt(cp_err_evt), .p_err_evt(p_err_evt),
        .los_lvl(los_lvl), .ais_lvl(ais_lvl), .idle_lvl(idle_lvl),
        .ferf_lvl(ferf_lvl), .aic_lvl(aic_lvl), .oof_lvl(oof_lvl),
        .irq_en(irq_en), .irq(irq)
    );

    function automatic bit [7:0] cur_inputs();
        return {cp_err_evt, los_lvl, ais_lvl, idle_lvl, ferf_lvl, aic_lvl, oof_lvl, p_err_evt};
    endfunction

    always @(posedge clk) begin
        bit [7:0] in_v;
        bit [7:0] ev;
        bit       hit;
        if (!rst_n) begin
            m_flags = 8'h40;
            m_rd    = 8'h00;
            m_prev  = 8'h00;
        end else begin
            in_v = cur_inputs();
            ev   = 8'h00;
            for (int b = 0; b < 8; b++) begin
                if (b == 0 || b == 7) ev[b] = in_v[b];
                else                  ev[b] = in_v[b] ^ m_prev[b];
            end
            if (!cbit_mode) ev[7] = 1'b0;
            m_prev = in_v;
            hit    = rd_en && (addr == 8'h13);
            m_rd   = hit ? m_flags : 8'h00;
            m_flags = (hit ? 8'h00 : m_flags) | ev;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(rd_data === m_rd, cur_req, rd_data, m_rd);
            chk(irq === |(m_flags & irq_en), "R9", irq, |(m_flags & irq_en));
        end
    end

    task automatic rd(input logic [7:0] a, output logic [7:0] v);
        @(negedge clk);
        addr  = a;
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        v = rd_data;
    endtask

    task automatic idle_cycles(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    initial begin
        logic [7:0] v;
        logic [15:0] lfsr;
        idle_cycles(3);
        rst_n = 1'b1;
        @(negedge clk);
        chk(rd_data === 8'h00, "R1", rd_data, 8'h00);
        chk(irq === 1'b0, "R1", irq, 0);

        cur_req = "R1";
        rd(8'h13, v); chk(v === 8'h40, "R1", v, 8'h40);
        cur_req = "R3";
        rd(8'h13, v); chk(v === 8'h00, "R3", v, 8'h00);

        cur_req = "R5";
        @(negedge clk); p_err_evt = 1'b1;
        @(negedge clk); p_err_evt = 1'b0;
        idle_cycles(5);
        rd(8'h13, v); chk(v === 8'h01, "R5", v, 8'h01);

        cur_req = "R6";
        @(negedge clk); ais_lvl = 1'b1;
        idle_cycles(2);
        rd(8'h13, v); chk(v === 8'h20, "R6", v, 8'h20);
        cur_req = "R10";
        idle_cycles(6);
        rd(8'h13, v); chk(v === 8'h00, "R10", v, 8'h00);
        cur_req = "R6";
        @(negedge clk); ais_lvl = 1'b0;
        idle_cycles(2);
        rd(8'h13, v); chk(v === 8'h20, "R6", v, 8'h20);

        cur_req = "R2";
        @(negedge clk); idle_lvl = 1'b1; los_lvl = 1'b1;
        idle_cycles(1);
        rd(8'h13, v); chk(v === 8'h50, "R2", v, 8'h50);
        @(negedge clk); idle_lvl = 1'b0; los_lvl = 1'b0;

        cur_req = "R7";
        rd(8'h13, v);
        @(negedge clk); cp_err_evt = 1'b1;
        @(negedge clk); cp_err_evt = 1'b0;
        rd(8'h13, v); chk(v === 8'h00, "R7", v, 8'h00);
        @(negedge clk); cbit_mode = 1'b1; cp_err_evt = 1'b1;
        @(negedge clk); cp_err_evt = 1'b0;
        rd(8'h13, v); chk(v === 8'h80, "R7", v, 8'h80);

        cur_req = "R4";
        @(negedge clk); oof_lvl = 1'b1;
        idle_cycles(1);
        rd(8'h12, v); chk(v === 8'h00, "R4", v, 8'h00);
        rd(8'h13, v); chk(v === 8'h02, "R4", v, 8'h02);

        cur_req = "R8";
        @(negedge clk); p_err_evt = 1'b1;
        @(negedge clk); p_err_evt = 1'b0;
        addr = 8'h13; rd_en = 1'b1; ferf_lvl = 1'b1;
        @(negedge clk); rd_en = 1'b0;
        chk(rd_data === 8'h01, "R8", rd_data, 8'h01);
        rd(8'h13, v); chk(v === 8'h08, "R8", v, 8'h08);

        cur_req = "R9";
        irq_en = 8'h04;
        @(negedge clk); aic_lvl = 1'b1;
        @(negedge clk);
        chk(irq === 1'b1, "R9", irq, 1);
        rd(8'h13, v);
        chk(irq === 1'b0, "R9", irq, 0);
        irq_en = 8'h00;
        @(negedge clk); oof_lvl = 1'b0;
        @(negedge clk);
        chk(irq === 1'b0, "R9", irq, 0);

        cur_req = "R3";
        irq_en = 8'hA5;
        lfsr = 16'hACE1;
        for (int c = 0; c < 600; c++) begin
            @(negedge clk);
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            rd_en      = lfsr[0] & lfsr[3];
            addr       = lfsr[5] ? 8'h13 : 8'h31;
            cp_err_evt = lfsr[1] & lfsr[7];
            p_err_evt  = lfsr[2] & lfsr[9];
            cbit_mode  = lfsr[11];
            if (lfsr[4] & lfsr[6]) los_lvl  = ~los_lvl;
            if (lfsr[8] & lfsr[6]) ais_lvl  = ~ais_lvl;
            if (lfsr[10] & lfsr[12]) idle_lvl = ~idle_lvl;
            if (lfsr[13] & lfsr[4]) ferf_lvl = ~ferf_lvl;
            if (lfsr[14] & lfsr[2]) aic_lvl  = ~aic_lvl;
            if (lfsr[15] & lfsr[1]) oof_lvl  = ~oof_lvl;
        end
        @(negedge clk);
        rd_en = 1'b0; cp_err_evt = 1'b0; p_err_evt = 1'b0;
        idle_cycles(3);

        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule